// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This unit decides, cycle by cycle, whether a processor core should start taking a hardware interrupt. It raises a one-cycle `take` pulse when the core should begin exception entry. The core holds `ack_busy` high while that entry is still under way.

A build-time parameter selects one of two controller styles.

- **Internal mode.** Up to 32 level-sensitive request lines pass through a two-flop synchroniser into a pending register. The pending register is masked by an enable register and by the global interrupt-enable bit in the status register.
- **External mode.** An outside controller presents one request at a time. Each request carries its priority level, the register set it wants and a non-maskable flag. The unit judges it against status fields in a fixed order: the non-maskable check first, then the global enable, then the level threshold, then the register-set comparison.

The unit also holds the status, enable and pending control registers. A small word-wide read/write port gives access to them.

The two fields that software cannot write in external mode are the NMI-active flag and the current register set. The core loads them through a dedicated update strobe when it switches context.

Top module: `intr_accept`

## Requirements
- R1: After reset `take` is low, status reads 0x0080_0000 (only the register-set interrupt enable, bit 23, set), and enable and pending read zero.
- R2: In internal mode each pending bit (address 2) follows its request line through two synchronising flops. A line that changes before clock edge N shows in pending after edge N+1. Writes to pending have no effect.
- R3: In internal mode an interrupt is wanted only when status bit 0 (global enable) is set and (pending AND enable) is nonzero. A line raised before edge N gives `take` high after edge N+2.
- R4: `take` is high for at most one cycle at a time. `take` stays low in the cycle after any edge at which `ack_busy` is high.
- R5: In external mode a request with the non-maskable flag set is taken exactly when status bit 22 (NMI active) is clear, whatever the other fields hold.
- R6: In external mode a maskable request is rejected when status bit 0 is clear. It is also rejected unless its level is strictly greater than status bits 9:4 (level threshold).
- R7: In external mode a maskable request that passes R6 is taken when its register set differs from status bits 15:10. If the sets match, it is taken only when status bit 23 is set.
- R8: In internal mode a status write changes only bits 0, 1 and 2. Bit 23 keeps its value and every other bit reads zero.
- R9: In external mode a status write changes bits 0–9, 16–21 and 23. Bits 22 and 15:10 change only through the core update strobe. Enable and pending read zero.
- R10: Register addresses are 0 status, 1 enable, 2 pending and 3 reads zero. In internal mode the enable register takes every written bit.
- R11: In internal mode the external request inputs and the core update strobe have no effect. In external mode the request lines have no effect. An external decision appears on `take` one edge after the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NLINES | Level-sensitive request lines (internal mode) |
| ext_req | input | 1 | External request valid |
| ext_nmi | input | 1 | External request is non-maskable |
| ext_level | input | 6 | External request priority level |
| ext_rset | input | 6 | Register set the external request targets |
| core_upd | input | 1 | Core loads NMI-active and current-set fields |
| core_nmi | input | 1 | New NMI-active value |
| core_crs | input | 6 | New current register set value |
| ack_busy | input | 1 | Core still entering the previous exception |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| take | output | 1 | One-cycle interrupt acceptance pulse |

## Verification
The bench checks the three-edge latency from a request line to `take`. A design with a missing or extra synchroniser stage would pulse one cycle early or late.

Held requests must produce alternating pulses, and pulses must stop while `ack_busy` is high. A design lacking the self-block would raise `take` for two cycles in a row.

In external mode the bench covers the following corner cases:
- A level exactly equal to the threshold, which a design using a non-strict comparison would accept.
- A matching register set with the register-set enable clear and then set.
- A non-maskable request with the global enable off, and then with the NMI-active bit set, which exposes a wrong check order.

Writes of all ones expose any mode mask that lets a read-only or reserved bit through.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int DW    = 32;
    localparam int LVL_W = 6;

    typedef struct packed {
        logic [7:0]       rsvd;
        logic             rsie;
        logic             nmi;
        logic [LVL_W-1:0] prs;
        logic [LVL_W-1:0] crs;
        logic [LVL_W-1:0] il;
        logic             ih;
        logic             eh;
        logic             u;
        logic             pie;
    } status_t;

    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_ENABLE  = 2'd1,
        RA_PENDING = 2'd2,
        RA_NONE    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             req;
        logic             nmi;
        logic [LVL_W-1:0] level;
        logic [LVL_W-1:0] rset;
    } ext_req_t;

    localparam logic [DW-1:0] ST_RESET  = 32'h0080_0000;
    localparam logic [DW-1:0] ST_WR_INT = 32'h0000_0007;
    localparam logic [DW-1:0] ST_RO_INT = 32'h0080_0000;
    localparam logic [DW-1:0] ST_WR_EXT = 32'h00BF_03FF;
    localparam logic [DW-1:0] ST_RO_EXT = 32'h0040_FC00;

    function automatic logic [DW-1:0] merge_write(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] wdata,
                                                  input logic [DW-1:0] wmask,
                                                  input logic [DW-1:0] romask);
        return (wdata & wmask) | (cur & romask);
    endfunction

    // Ordered acceptance: non-maskable, global enable, level, register set.
    function automatic logic ext_accept(input ext_req_t r,
                                        input logic pie,
                                        input logic [LVL_W-1:0] il,
                                        input logic [LVL_W-1:0] crs,
                                        input logic rsie,
                                        input logic nmi_active);
        if (!r.req)        return 1'b0;
        if (r.nmi)         return !nmi_active;
        if (!pie)          return 1'b0;
        if (r.level <= il) return 1'b0;
        if (r.rset != crs) return 1'b1;
        return rsie;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
    import intr_pkg::*;
#(
    parameter int unsigned EXT_MODE = 0,
    parameter int          NLINES   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              core_upd,
    input  logic              core_nmi,
    input  logic [LVL_W-1:0]  core_crs,
    input  logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] en,
    output logic              st_pie,
    output logic [LVL_W-1:0]  st_il,
    output logic [LVL_W-1:0]  st_crs,
    output logic              st_rsie,
    output logic              st_nmi
);
    localparam logic [DW-1:0] WMASK = (EXT_MODE != 0) ? ST_WR_EXT : ST_WR_INT;
    localparam logic [DW-1:0] RMASK = (EXT_MODE != 0) ? ST_RO_EXT : ST_RO_INT;

    status_t st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        if (we && addr == RA_STATUS)
            st_nx = status_t'(merge_write(st_q, wdata, WMASK, RMASK));
        if (EXT_MODE != 0 && core_upd) begin
            st_nx.nmi = core_nmi;
            st_nx.crs = core_crs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= status_t'(ST_RESET);
        else     st_q <= st_nx;
    end

    if (EXT_MODE == 0) begin : g_en
        logic [NLINES-1:0] en_q;
        always_ff @(posedge clk) begin
            if (rst)                          en_q <= '0;
            else if (we && addr == RA_ENABLE) en_q <= wdata[NLINES-1:0];
        end
        assign en = en_q;
    end else begin : g_noen
        assign en = '0;
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_STATUS:  rdata = st_q;
            RA_ENABLE:  rdata = DW'(en);
            RA_PENDING: rdata = (EXT_MODE != 0) ? '0 : DW'(pend);
            default:    rdata = '0;
        endcase
    end

    assign st_pie  = st_q.pie;
    assign st_il   = st_q.il;
    assign st_crs  = st_q.crs;
    assign st_rsie = st_q.rsie;
    assign st_nmi  = st_q.nmi;
endmodule

// File: rtl/accept_eval.sv
module accept_eval
    import intr_pkg::*;
#(
    parameter int unsigned EXT_MODE = 0,
    parameter int          NLINES   = 32
) (
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] en,
    input  logic              pie,
    input  logic [LVL_W-1:0]  il,
    input  logic [LVL_W-1:0]  crs,
    input  logic              rsie,
    input  logic              nmi_active,
    input  ext_req_t          xr,
    output logic              want
);
    logic want_int, want_ext;

    assign want_int = pie && ((pend & en) != '0);
    assign want_ext = ext_accept(xr, pie, il, crs, rsie, nmi_active);
    assign want     = (EXT_MODE != 0) ? want_ext : want_int;
endmodule

// File: rtl/intr_accept.sv
module intr_accept
    import intr_pkg::*;
#(
    parameter int unsigned EXT_MODE = 0,
    parameter int          NLINES   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              ext_req,
    input  logic              ext_nmi,
    input  logic [LVL_W-1:0]  ext_level,
    input  logic [LVL_W-1:0]  ext_rset,
    input  logic              core_upd,
    input  logic              core_nmi,
    input  logic [LVL_W-1:0]  core_crs,
    input  logic              ack_busy,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              take
);
    logic [NLINES-1:0] pend, en;
    logic              st_pie, st_rsie, st_nmi;
    logic [LVL_W-1:0]  st_il, st_crs;
    logic              want, take_q;
    ext_req_t          xr;

    assign xr = '{req: ext_req, nmi: ext_nmi, level: ext_level, rset: ext_rset};

    irq_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst(rst), .d(irq_lines), .q(pend)
    );

    ctl_regs #(.EXT_MODE(EXT_MODE), .NLINES(NLINES)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .core_upd(core_upd), .core_nmi(core_nmi), .core_crs(core_crs),
        .pend(pend), .en(en),
        .st_pie(st_pie), .st_il(st_il), .st_crs(st_crs),
        .st_rsie(st_rsie), .st_nmi(st_nmi)
    );

    accept_eval #(.EXT_MODE(EXT_MODE), .NLINES(NLINES)) u_eval (
        .pend(pend), .en(en), .pie(st_pie), .il(st_il), .crs(st_crs),
        .rsie(st_rsie), .nmi_active(st_nmi), .xr(xr), .want(want)
    );

    always_ff @(posedge clk) begin
        if (rst) take_q <= 1'b0;
        else     take_q <= want && !ack_busy && !take_q;
    end

    assign take = take_q;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk #(
    parameter int unsigned EXT_MODE = 0
) (
    input logic clk,
    input logic rst,
    input logic take,
    input logic ack_busy,
    input logic ext_req,
    input logic ext_nmi,
    input logic st_pie,
    input logic st_nmi,
    input logic st_rsie
);
    localparam logic IS_EXT = (EXT_MODE != 0);

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !take);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    a_r4_ack_holdoff: assert property (@(posedge clk) disable iff (rst)
        ack_busy |=> !take);

    a_r3_pie_gate: assert property (@(posedge clk) disable iff (rst)
        (!IS_EXT && !st_pie) |=> !take);

    a_r8_rsie_fixed: assert property (@(posedge clk) disable iff (rst)
        !IS_EXT |-> st_rsie);

    a_r5_nmi_taken: assert property (@(posedge clk) disable iff (rst)
        (IS_EXT && ext_req && ext_nmi && !st_nmi && !ack_busy && !take) |=> take);

    a_r5_nmi_blocked: assert property (@(posedge clk) disable iff (rst)
        (IS_EXT && ext_req && ext_nmi && st_nmi) |=> !take);

    a_r6_pie_gate: assert property (@(posedge clk) disable iff (rst)
        (IS_EXT && ext_req && !ext_nmi && !st_pie) |=> !take);
endmodule

bind intr_accept intr_accept_chk #(.EXT_MODE(EXT_MODE)) u_chk (
    .clk(clk), .rst(rst), .take(take), .ack_busy(ack_busy),
    .ext_req(ext_req), .ext_nmi(ext_nmi),
    .st_pie(st_pie), .st_nmi(st_nmi), .st_rsie(st_rsie)
);

// File: tb/sim_intr_accept.sv
`timescale 1ns/1ps
module sim_intr_accept;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq = '0;
    logic        xreq = 0, xnmi = 0;
    logic [5:0]  xlvl = '0, xrs = '0;
    logic        cupd = 0, cnmi = 0;
    logic [5:0]  ccrs = '0;
    logic        ack = 0;
    logic        we0 = 0, we1 = 0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        take0, take1;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  t0;
        logic  t1;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    intr_accept #(.EXT_MODE(0)) u0 (
        .clk(clk), .rst(rst), .irq_lines(irq), .ext_req(xreq), .ext_nmi(xnmi),
        .ext_level(xlvl), .ext_rset(xrs), .core_upd(cupd), .core_nmi(cnmi),
        .core_crs(ccrs), .ack_busy(ack), .reg_we(we0), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd0), .take(take0)
    );

    intr_accept #(.EXT_MODE(1)) u1 (
        .clk(clk), .rst(rst), .irq_lines(irq), .ext_req(xreq), .ext_nmi(xnmi),
        .ext_level(xlvl), .ext_rset(xrs), .core_upd(cupd), .core_nmi(cnmi),
        .core_crs(ccrs), .ack_busy(ack), .reg_we(we1), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd1), .take(take1)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic cyc(input logic e0, input logic e1, input string tag);
        exp_t x;
        x.t0 = e0; x.t1 = e1; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic wr(input bit which, input logic [1:0] a, input logic [31:0] d,
                      input logic e0, input logic e1, input string tag);
        addr = a; wdata = d; we0 = !which; we1 = which;
        cyc(e0, e1, tag);
        we0 = 0; we1 = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] x0, input logic [31:0] x1,
                      input string tag);
        addr = a;
        #1;
        chk(rd0, x0, {tag, " u0 read"});
        chk(rd1, x1, {tag, " u1 read"});
    endtask

    task automatic ex(input logic n, input logic [5:0] lv, input logic [5:0] rs,
                      input logic e, input string tag);
        xreq = 1; xnmi = n; xlvl = lv; xrs = rs;
        cyc(0, e, tag);
        xreq = 0; xnmi = 0;
        cyc(0, 0, tag);
    endtask

    // Scoreboard monitor: compares take one step after every edge that has an expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                chk({31'b0, take0}, {31'b0, x.t0}, {x.tag, " u0 take"});
                chk({31'b0, take1}, {31'b0, x.t1}, {x.tag, " u1 take"});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk({31'b0, take0}, 32'h0, "R1 u0 take");
        chk({31'b0, take1}, 32'h0, "R1 u1 take");
        rd(2'd0, 32'h0080_0000, 32'h0080_0000, "R1 status");
        rd(2'd1, 32'h0, 32'h0, "R1 enable");
        rd(2'd2, 32'h0, 32'h0, "R1 pending");
        rd(2'd3, 32'h0, 32'h0, "R10 unused address");

        // Internal mode set-up
        wr(0, 2'd1, 32'h0000_0001, 0, 0, "R10 enable write");
        wr(0, 2'd0, 32'hFFFF_FFFF, 0, 0, "R8 status write");
        wr(1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R9 enable write ext");
        rd(2'd0, 32'h0080_0007, 32'h0080_0000, "R8 status mask");
        rd(2'd1, 32'h0000_0001, 32'h0, "R10 R9 enable");

        irq = 32'h2;                       // line not enabled
        repeat (4) cyc(0, 0, "R3 masked line");
        rd(2'd2, 32'h2, 32'h0, "R2 R11 pending");
        wr(0, 2'd2, 32'h0, 0, 0, "R2 pending write");
        rd(2'd2, 32'h2, 32'h0, "R2 pending read-only");

        irq = 32'h3;                       // enabled line rises
        cyc(0, 0, "R3 sync stage 1");
        cyc(0, 0, "R3 sync stage 2");
        cyc(1, 0, "R3 latency");
        cyc(0, 0, "R4 single pulse");
        cyc(1, 0, "R4 repeat pulse");
        ack = 1;
        repeat (3) cyc(0, 0, "R4 ack holdoff");
        ack = 0;
        cyc(1, 0, "R4 ack release");
        wr(0, 2'd0, 32'h0, 0, 0, "R3 clear global enable");
        repeat (3) cyc(0, 0, "R3 global enable clear");

        irq = 32'h0;
        repeat (3) cyc(0, 0, "R2 lines low");
        wr(0, 2'd0, 32'h0000_0001, 0, 0, "R3 set global enable");
        repeat (2) cyc(0, 0, "R3 nothing pending");
        rd(2'd2, 32'h0, 32'h0, "R2 pending cleared");

        // External mode
        wr(1, 2'd0, 32'h0000_0031, 0, 0, "R9 status write");
        rd(2'd0, 32'h0080_0001, 32'h0000_0031, "R9 status readback");
        ex(0, 6'd4, 6'd1, 1, "R6 R7 above level, set differs");
        ex(0, 6'd3, 6'd1, 0, "R6 level equal");
        ex(0, 6'd2, 6'd1, 0, "R6 level below");
        ex(0, 6'd4, 6'd0, 0, "R7 same set rsie clear");
        ex(1, 6'd0, 6'd0, 1, "R5 R11 nmi taken");
        wr(1, 2'd0, 32'h0000_0030, 0, 0, "R6 clear global enable");
        ex(0, 6'd9, 6'd1, 0, "R6 global enable clear");
        ex(1, 6'd0, 6'd0, 1, "R5 nmi ignores global enable");
        wr(1, 2'd0, 32'h0080_0031, 0, 0, "R7 set rsie");
        ex(0, 6'd4, 6'd0, 1, "R7 same set rsie set");

        cupd = 1; cnmi = 1; ccrs = 6'd2;
        cyc(0, 0, "R9 core update");
        cupd = 0;
        rd(2'd0, 32'h0080_0001, 32'h00C0_0831, "R9 R11 core update");
        ex(1, 6'd0, 6'd0, 0, "R5 nmi blocked");
        ex(0, 6'd4, 6'd2, 1, "R7 matches updated set");
        ex(0, 6'd4, 6'd3, 1, "R7 differs from updated set");
        wr(1, 2'd0, 32'hFFFF_FFFF, 0, 0, "R9 write all ones");
        rd(2'd0, 32'h0080_0001, 32'h00FF_0BFF, "R9 status mask");
        ex(0, 6'd63, 6'd0, 0, "R6 level at max threshold");
        rd(2'd1, 32'h0000_0001, 32'h0, "R9 enable ext");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule